// File: doc/BRIEF.md
# Three-Pulse Bus Handover Controller

This block lets up to two alternate masters borrow the local bus from a host bus unit. Each master shares one active-low wire with the block. A handover uses three single-clock low pulses on that wire. The master pulses to ask for the bus. The block answers with a grant pulse once the host has reached a point where it may let go. The master pulses a third time to give the bus back. Between grant and release the block raises a busy flag that keeps the host sequencer off the bus. After every exchange a recovery window of idle clocks follows.

The open-drain wire is split into a sampled level input and a pull-low enable output per line. The host sequencer itself lies outside the block. It reports the state of its current cycle through a small set of status inputs, all valid for the clock in which they are sampled:
- a cycle is active;
- this clock is T4;
- this clock is T1 or T2;
- the cycle is the low byte of an odd-address word;
- the cycle is the first interrupt-acknowledge cycle;
- a locked instruction is running.

Top module: `rqg_handshake`

## Requirements
- R1: While reset is held and in the first clock after it, every pull-low enable and the busy flag are 0.
- R2: A request is a high-to-low transition of a line's sampled level. When a request is sampled in a clock where no host cycle is active, the block drives that line low in the very next clock. Busy goes high in that same clock.
- R3: The grant pulse lasts exactly one clock, and only the granted line's pull-low enable is set.
- R4: During an active host cycle, a grant is decided only on a clock flagged T4, and the grant pulse follows that clock. A request sampled in T1 or T2 of a qualifying cycle is granted right after that cycle's T4.
- R5: A request first sampled in T3, in a wait clock or in T4 is not granted after that cycle's T4. It is granted after the next qualifying T4 or the next idle clock.
- R6: A T4 never leads to a grant while any of these flags is set: odd-address low byte, first interrupt acknowledge, or locked. The request stays pending.
- R7: Busy stays 1 from the grant clock until a low level is sampled on the granted line, with the grant clock itself excluded. Busy drops in the clock after that release pulse.
- R8: For RECOVER_CLKS clocks after the release has been sampled, request pulses on any line are ignored and produce no grant.
- R9: If both lines request in the same clock, line 0 (bit 0) is served.
- R10: Request pulses are ignored while a request is pending or the bus is granted, and they are not queued. This covers the other line and a repeat on the same line.
- R11: A line held low across several clocks counts as a single request, not as repeated requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rg_line_n | input | NUM_LINES | Sampled level of each request/grant wire (0 = pulled low) |
| rg_pull_lo | output | NUM_LINES | Pull-low enable per wire, set during the grant pulse |
| cyc_active | input | 1 | Host bus cycle in progress this clock |
| cyc_t4 | input | 1 | This clock is T4 of the active cycle |
| cyc_early | input | 1 | This clock is T1 or T2 of the active cycle |
| cyc_odd_low | input | 1 | Active cycle is the low byte of an odd-address word |
| cyc_inta_first | input | 1 | Active cycle is the first interrupt-acknowledge cycle |
| cyc_locked | input | 1 | A locked instruction is executing |
| host_busy | output | 1 | Host must stay off the bus (grant through release) |

## Verification
On every clock the assertions check the shape of the grant output:
- at most one line is pulled low, and only for a single clock;
- busy covers the grant clock and the clock that follows it;
- every grant follows an idle or T4 clock that has no blocking flag;
- busy falls only after a low level was seen on a line.

Some properties cannot be seen clock by clock, and only the bench scenarios can show them:
- line 0 wins over line 1;
- requests are lost rather than queued during an exchange or during recovery;
- a request arriving in T3 slips to the next cycle.

// File: rtl/rqg_pkg.sv
package rqg_pkg;

   typedef enum logic [2:0] {
      RQG_IDLE  = 3'd0,
      RQG_PEND  = 3'd1,
      RQG_GRANT = 3'd2,
      RQG_HELD  = 3'd3,
      RQG_RECOV = 3'd4
   } rqg_state_e;

   typedef struct packed {
      logic active;
      logic t4;
      logic early;
      logic odd_low;
      logic inta_first;
      logic locked;
   } rqg_cyc_t;

endpackage

// File: rtl/rqg_pulse_detect.sv
module rqg_pulse_detect #(
   parameter int NUM_LINES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_n,
   output logic [NUM_LINES-1:0] fall
);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= line_n[gi];
         end
         assign fall[gi] = prev_q & ~line_n[gi];
      end
   endgenerate

endmodule

// File: rtl/rqg_prio_pick.sv
module rqg_prio_pick #(
   parameter int NUM_LINES = 2,
   parameter int IDX_W     = 1
) (
   input  logic [NUM_LINES-1:0] req,
   output logic                 vld,
   output logic [IDX_W-1:0]     idx
);

   generate
      if (NUM_LINES == 1) begin : g_single
         assign vld = req[0];
         assign idx = '0;
      end else begin : g_multi
         always_comb begin
            idx = '0;
            for (int i = NUM_LINES - 1; i >= 0; i--) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
         assign vld = |req;
      end
   endgenerate

endmodule

// File: rtl/rqg_release_gate.sv
module rqg_release_gate
   import rqg_pkg::*;
(
   input  rqg_cyc_t cyc,
   input  logic     early_ok,
   output logic     rel_ok
);

   logic blockers;

   always_comb begin
      blockers = cyc.odd_low | cyc.inta_first | cyc.locked;
      if (!cyc.active) rel_ok = 1'b1;
      else             rel_ok = cyc.t4 & early_ok & ~blockers;
   end

endmodule

// File: rtl/rqg_handshake.sv
module rqg_handshake
   import rqg_pkg::*;
#(
   parameter int NUM_LINES    = 2,
   parameter int RECOVER_CLKS = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] rg_line_n,
   output logic [NUM_LINES-1:0] rg_pull_lo,
   input  logic                 cyc_active,
   input  logic                 cyc_t4,
   input  logic                 cyc_early,
   input  logic                 cyc_odd_low,
   input  logic                 cyc_inta_first,
   input  logic                 cyc_locked,
   output logic                 host_busy
);

   localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
   localparam int RCV_W = $clog2(RECOVER_CLKS + 1);

   generate
      if (NUM_LINES < 1 || NUM_LINES > 2) begin : g_bad_lines
         $error("rqg_handshake: NUM_LINES must be 1 or 2");
      end
      if (RECOVER_CLKS < 1) begin : g_bad_recov
         $error("rqg_handshake: RECOVER_CLKS must be at least 1");
      end
   endgenerate

   rqg_state_e           state_q, state_d;
   logic [IDX_W-1:0]     owner_q, owner_d;
   logic                 early_q, early_d;
   logic [RCV_W-1:0]     rcv_q, rcv_d;
   logic [NUM_LINES-1:0] pull_q, pull_d;
   logic                 busy_q;

   logic [NUM_LINES-1:0] fall_w;
   logic                 pick_vld;
   logic [IDX_W-1:0]     pick_idx;
   logic                 early_eff;
   logic                 rel_ok;
   logic                 owner_low;
   rqg_cyc_t             cyc;

   assign cyc = '{active:     cyc_active,
                  t4:         cyc_t4,
                  early:      cyc_early,
                  odd_low:    cyc_odd_low,
                  inta_first: cyc_inta_first,
                  locked:     cyc_locked};

   rqg_pulse_detect #(.NUM_LINES(NUM_LINES)) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_n (rg_line_n),
      .fall   (fall_w)
   );

   rqg_prio_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick (
      .req (fall_w),
      .vld (pick_vld),
      .idx (pick_idx)
   );

   // a fresh request counts as early when seen outside a cycle or in T1/T2
   assign early_eff = (state_q == RQG_PEND) ? early_q : (~cyc_active | cyc_early);

   rqg_release_gate u_gate (
      .cyc      (cyc),
      .early_ok (early_eff),
      .rel_ok   (rel_ok)
   );

   assign owner_low = ~rg_line_n[owner_q];

   always_comb begin
      state_d = state_q;
      owner_d = owner_q;
      early_d = early_q;
      rcv_d   = rcv_q;
      unique case (state_q)
         RQG_IDLE: begin
            if (pick_vld) begin
               owner_d = pick_idx;
               early_d = ~cyc_active | cyc_early | cyc_t4;
               state_d = rel_ok ? RQG_GRANT : RQG_PEND;
            end
         end
         RQG_PEND: begin
            if (rel_ok)                  state_d = RQG_GRANT;
            else if (cyc_active & cyc_t4) early_d = 1'b1;
         end
         RQG_GRANT: state_d = RQG_HELD;
         RQG_HELD: begin
            if (owner_low) begin
               state_d = RQG_RECOV;
               rcv_d   = '0;
            end
         end
         RQG_RECOV: begin
            if (rcv_q == RCV_W'(RECOVER_CLKS - 1)) state_d = RQG_IDLE;
            else                                   rcv_d   = rcv_q + 1'b1;
         end
         default: state_d = RQG_IDLE;
      endcase
   end

   always_comb begin
      pull_d = '0;
      if (state_d == RQG_GRANT) pull_d[owner_d] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RQG_IDLE;
         owner_q <= '0;
         early_q <= 1'b0;
         rcv_q   <= '0;
         pull_q  <= '0;
         busy_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         owner_q <= owner_d;
         early_q <= early_d;
         rcv_q   <= rcv_d;
         pull_q  <= pull_d;
         busy_q  <= (state_d == RQG_GRANT) || (state_d == RQG_HELD);
      end
   end

   assign rg_pull_lo = pull_q;
   assign host_busy  = busy_q;

endmodule

// File: rtl/rqg_handshake_chk.sv
module rqg_handshake_chk #(
   parameter int NUM_LINES = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] rg_line_n,
   input logic [NUM_LINES-1:0] rg_pull_lo,
   input logic                 cyc_active,
   input logic                 cyc_t4,
   input logic                 cyc_odd_low,
   input logic                 cyc_inta_first,
   input logic                 cyc_locked,
   input logic                 host_busy
);

   AST_PULL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rg_pull_lo)); // R3
   AST_PULL_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) (|rg_pull_lo) |=> !(|rg_pull_lo)); // R3
   AST_BUSY_AT_GRANT: assert property (@(posedge clk) disable iff (!rst_n) (|rg_pull_lo) |-> host_busy); // R2
   AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n) (|rg_pull_lo) |=> host_busy); // R7
   AST_GRANT_AT_T4_OR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (|rg_pull_lo) |-> $past(!cyc_active || cyc_t4)); // R4
   AST_GRANT_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (|rg_pull_lo) |-> $past(!(cyc_active && (cyc_odd_low || cyc_inta_first || cyc_locked)))); // R6
   AST_BUSY_FALL_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $fell(host_busy) |-> !$past(&rg_line_n)); // R7

endmodule

bind rqg_handshake rqg_handshake_chk #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rg_line_n      (rg_line_n),
   .rg_pull_lo     (rg_pull_lo),
   .cyc_active     (cyc_active),
   .cyc_t4         (cyc_t4),
   .cyc_odd_low    (cyc_odd_low),
   .cyc_inta_first (cyc_inta_first),
   .cyc_locked     (cyc_locked),
   .host_busy      (host_busy)
);

// File: tb/tb_rqg_handshake.sv
`timescale 1ns/1ps
module tb_rqg_handshake;

   localparam int NL   = 2;
   localparam int RCVN = 1;
   localparam int M_IDLE = 0, M_PEND = 1, M_GRANT = 2, M_HELD = 3, M_RECOV = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] ext_lo = '0;
   logic [NL-1:0] rg_line_n;
   logic [NL-1:0] rg_pull_lo;
   logic          c_act = 0, c_t4 = 0, c_early = 0, c_odd = 0, c_inta = 0, c_lock = 0;
   logic          host_busy;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // model state
   int            m_st = M_IDLE;
   int            m_own = 0;
   bit            m_early = 0;
   int            m_cnt = 0;
   logic [NL-1:0] m_prev = '1;
   logic [NL-1:0] m_drv  = '0;
   bit            m_busy = 0;

   always #5 clk = ~clk;

   assign rg_line_n = ~(ext_lo | rg_pull_lo);

   rqg_handshake #(.NUM_LINES(NL), .RECOVER_CLKS(RCVN)) dut (
      .clk (clk), .rst_n (rst_n), .rg_line_n (rg_line_n), .rg_pull_lo (rg_pull_lo),
      .cyc_active (c_act), .cyc_t4 (c_t4), .cyc_early (c_early), .cyc_odd_low (c_odd),
      .cyc_inta_first (c_inta), .cyc_locked (c_lock), .host_busy (host_busy)
   );

   function automatic bit rel_ok(bit early_ok);
      if (!c_act) return 1'b1;
      return c_t4 && early_ok && !c_odd && !c_inta && !c_lock;
   endfunction

   task automatic model_edge();
      logic [NL-1:0] line;
      logic [NL-1:0] fall;
      int nst;
      line = ~(ext_lo | m_drv);
      fall = m_prev & ~line;
      nst  = m_st;
      if (!rst_n) begin
         m_st = M_IDLE; m_own = 0; m_early = 0; m_cnt = 0; m_prev = '1;
         m_drv = '0; m_busy = 0;
         return;
      end
      case (m_st)
         M_IDLE: if (fall != 0) begin
            m_own   = fall[0] ? 0 : 1;
            nst     = rel_ok(!c_act || c_early) ? M_GRANT : M_PEND;
            m_early = !c_act || c_early || c_t4;
         end
         M_PEND: begin
            if (rel_ok(m_early)) nst = M_GRANT;
            else if (c_act && c_t4) m_early = 1;
         end
         M_GRANT: nst = M_HELD;
         M_HELD: if (!line[m_own]) begin nst = M_RECOV; m_cnt = 0; end
         M_RECOV: if (m_cnt == RCVN - 1) nst = M_IDLE; else m_cnt++;
         default: nst = M_IDLE;
      endcase
      m_prev = line;
      m_st   = nst;
      m_drv  = (nst == M_GRANT) ? (NL'(1) << m_own) : '0;
      m_busy = (nst == M_GRANT) || (nst == M_HELD);
   endtask

   task automatic check(string tag, logic [NL-1:0] exp_pull, bit exp_busy);
      n_chk++;
      if (rg_pull_lo !== exp_pull || host_busy !== exp_busy) begin
         n_bad++;
         $display("FAIL %s: pull=%b busy=%b expected pull=%b busy=%b at %0t",
                  tag, rg_pull_lo, host_busy, exp_pull, exp_busy, $time);
      end
   endtask

   // one clock: posedge updates model, negedge compares
   task automatic tick(string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(tag, m_drv, m_busy);
   endtask

   task automatic set_cyc(bit act, int ph, bit odd, bit inta, bit lock);
      c_act = act; c_t4 = act && ph == 4; c_early = act && (ph == 1 || ph == 2);
      c_odd = act && odd; c_inta = act && inta; c_lock = act && lock;
   endtask

   task automatic pulse(logic [NL-1:0] which, string tag);
      ext_lo = which; tick(tag); ext_lo = '0;
   endtask

   task automatic run_cycle(bit odd, bit inta, bit lock, string tag);
      for (int p = 1; p <= 4; p++) begin set_cyc(1, p, odd, inta, lock); tick(tag); end
   endtask

   task automatic release_line(logic [NL-1:0] which, string tag);
      set_cyc(0, 0, 0, 0, 0);
      tick(tag);
      pulse(which, tag);
      for (int k = 0; k < RCVN + 1; k++) tick(tag);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      @(negedge clk);
      for (int i = 0; i < 3; i++) tick("R1 reset");
      check("R1 in reset", '0, 0);
      rst_n = 1'b1;
      tick("R1 after reset");
      check("R1 first clock", '0, 0);

      // R2: request in idle clock
      pulse(2'b01, "R2 request");
      check("R2 grant next clock", 2'b01, 1);
      tick("R3 pulse end");
      check("R3 single clock grant", 2'b00, 1);
      tick("R7 held"); tick("R7 held");
      check("R7 busy while held", 2'b00, 1);
      pulse(2'b01, "R7 release");
      check("R7 busy drops", 2'b00, 0);
      // R8: pulse in recovery clock ignored
      pulse(2'b10, "R8 recovery pulse");
      tick("R8 after recovery");
      check("R8 ignored request", 2'b00, 0);

      // R4: request in T2 of qualifying cycle
      set_cyc(1, 1, 0, 0, 0); tick("R4 T1");
      set_cyc(1, 2, 0, 0, 0); pulse(2'b10, "R4 T2 request");
      check("R4 no grant before T4", 2'b00, 0);
      set_cyc(1, 3, 0, 0, 0); tick("R4 T3");
      set_cyc(1, 4, 0, 0, 0); tick("R4 T4");
      check("R4 grant after T4", 2'b10, 1);
      release_line(2'b10, "R4 release");

      // R5: request in T3 slips past this T4
      set_cyc(1, 3, 0, 0, 0); pulse(2'b01, "R5 T3 request");
      set_cyc(1, 4, 0, 0, 0); tick("R5 T4");
      check("R5 no grant at late T4", 2'b00, 0);
      run_cycle(0, 0, 0, "R5 next cycle");
      check("R5 grant after next T4", 2'b01, 1);
      release_line(2'b01, "R5 release");

      // R6: each blocker
      for (int b = 0; b < 3; b++) begin
         set_cyc(1, 1, b == 0, b == 1, b == 2); pulse(2'b01, "R6 request");
         for (int p = 2; p <= 4; p++) begin set_cyc(1, p, b == 0, b == 1, b == 2); tick("R6 blocked"); end
         check("R6 blocked T4", 2'b00, 0);
         run_cycle(b == 0, b == 1, b == 2, "R6 still blocked");
         check("R6 still pending", 2'b00, 0);
         set_cyc(0, 0, 0, 0, 0); tick("R6 idle");
         check("R6 grant on idle", 2'b01, 1);
         tick("R6 held");
         release_line(2'b01, "R6 release");
      end

      // R9: simultaneous
      pulse(2'b11, "R9 both request");
      check("R9 line 0 wins", 2'b01, 1);
      tick("R10 held");
      pulse(2'b10, "R10 other line while held");
      check("R10 no grant other line", 2'b00, 1);
      release_line(2'b01, "R10 release");
      tick("R10 idle");
      check("R10 not queued", 2'b00, 0);

      // R11: line held low several clocks = one request
      ext_lo = 2'b10; tick("R11 low 1");
      check("R11 grant once", 2'b10, 1);
      tick("R11 low 2"); tick("R11 low 3");
      ext_lo = '0; tick("R11 high");
      check("R11 released by long low", 2'b00, 0);
      for (int k = 0; k < 3; k++) tick("R11 idle");
      check("R11 no repeat", 2'b00, 0);

      // random phase
      begin
         int ph = 0;
         bit odd = 0, inta = 0, lock = 0;
         for (int n = 0; n < 4000; n++) begin
            if (ph == 0) begin
               if ($urandom_range(1, 0) == 1) begin
                  ph = 1; odd = ($urandom_range(7, 0) == 0);
                  inta = ($urandom_range(7, 0) == 0); lock = ($urandom_range(5, 0) == 0);
               end
            end else if (ph == 3 && $urandom_range(3, 0) == 0) begin
               ph = 3;
            end else begin
               ph = (ph == 4) ? 0 : ph + 1;
            end
            set_cyc(ph != 0, (ph == 0) ? 1 : ph, odd, inta, lock);
            ext_lo[0] = ($urandom_range(9, 0) == 0);
            ext_lo[1] = ($urandom_range(9, 0) == 0);
            tick("R2 R4 R5 R6 R7 R9 random");
         end
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule